// File: doc/BRIEF.md
# Packet-Mode I2C Transfer Header Decoder

This block is the front end of a packet-driven I2C master. Software does not program a command register. It pushes 32-bit words into a transmit word FIFO. Each transfer starts with three header words: a protocol word, a length word and a flags/address word. For a write, the payload words come next. The decoder pops the header words and turns them into one command record for a bit-level engine. The record carries the target address, the 7- or 10-bit addressing mode, the direction, the byte count and the action to take when the packet ends. For a write, the decoder then hands the payload to the engine one byte at a time.

For a read, no payload words follow the header. The decoder takes the bytes the engine receives and packs them into 32-bit words. When the engine reports that the last byte and the closing bus action are finished, the decoder pulses a packet-complete output for one cycle. A NAK from the target becomes an error flag unless the header asked the block to ignore it. A first header word without the protocol flag is discarded and sets a sticky status bit.

Top module: `pkt_hdr_dec`

## Requirements
- R1: After reset, `cmd_valid`, `tx_valid`, `rxw_valid`, `pkt_done`, `nak_err` and `bad_hdr` are low. With the FIFO empty, `fifo_pop` is low.
- R2: A first header word with bit 4 clear is popped and dropped. No command is issued for it, and `bad_hdr` goes high and stays high until reset. The next word is again treated as a first header word.
- R3: Bits 11:0 of the second header word hold the byte count minus one. `cmd_len` reports the count itself, from 1 to 4096.
- R4: If bit 18 of the third header word is clear, `cmd_addr` is that word's bits 7:1 (7-bit target) and `cmd_ten_bit` is 0. If bit 18 is set, `cmd_addr` is bits 9:0 and `cmd_ten_bit` is 1.
- R5: If bit 19 of the third word is set, `cmd_read` is 1 and no payload word is popped. Received bytes are packed lowest byte first, and `rxw_valid` pulses with each full word. A final partial word is sent with its unused upper bytes at zero.
- R6: `cmd_end` takes its value from bits 16 and 15 of the third word. Bit 16 set gives 1 (repeated start), and it wins if bit 15 is also set. Bit 15 alone gives 2 (no stop, no start). Neither bit gives 0 (stop).
- R7: Write payload bytes go to `tx_byte` lowest byte of each word first, held until `tx_ready`. Bytes past the count in the last word are never sent, and the next word is parsed as a new header.
- R8: `fifo_pop` is never high while `fifo_empty` is high.
- R9: `pkt_done` goes high for exactly one cycle, in the cycle after `eng_done` is sampled while the block waits for the engine.
- R10: A NAK from the engine while bit 21 of the third word is clear sets `nak_err`. It also forces `cmd_end` to 0 (stop) and stops the byte stream, without popping further payload. `pkt_done` still follows `eng_done`. If bit 21 is set, the NAK is ignored and the packet runs to its end unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_empty | input | 1 | Transmit word FIFO is empty |
| fifo_data | input | 32 | Head word of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Consume the head word at this edge |
| cmd_valid | output | 1 | One-cycle pulse: command fields are new |
| cmd_addr | output | 10 | Target address |
| cmd_ten_bit | output | 1 | 10-bit addressing |
| cmd_read | output | 1 | Read transfer |
| cmd_len | output | LEN_W+1 | Byte count, 1 to 2^LEN_W |
| cmd_end | output | 2 | End action: 0 stop, 1 repeated start, 2 continue |
| tx_valid | output | 1 | A payload byte is offered |
| tx_byte | output | 8 | Payload byte |
| tx_ready | input | 1 | Engine accepts the byte |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rxw_valid | output | 1 | Packed receive word is valid |
| rxw_data | output | 32 | Packed receive word |
| eng_nak | input | 1 | Engine saw a NAK |
| eng_done | input | 1 | Engine finished the last byte and the end action |
| pkt_done | output | 1 | One-cycle packet-complete pulse |
| nak_err | output | 1 | No-ack error for the current packet |
| bad_hdr | output | 1 | Sticky: a malformed first header word was dropped |

## Verification
The bench targets the length boundaries: a count field of zero (one byte), exactly one payload word, and the full 4096 bytes. An off-by-one in the count would send one byte too few or too many, and a short last word would then leak its padding bytes onto the bus. It also sets both end-action bits at once, where a decoder with the wrong priority would report a continue instead of a repeated start. A NAK is injected while a payload word is already loaded. A design that kept streaming, kept the header's end action, or popped the next payload word would all be caught here, and so would one that flagged the NAK even though the header asked for it to be ignored. Reads check that no payload is consumed and that a trailing partial receive word is zero-padded and not dropped.

// File: rtl/pkt_hdr_dec.sv
module pkt_hdr_dec #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_empty,
  input  logic [31:0]      fifo_data,
  output logic             fifo_pop,
  output logic             cmd_valid,
  output logic [9:0]       cmd_addr,
  output logic             cmd_ten_bit,
  output logic             cmd_read,
  output logic [LEN_W:0]   cmd_len,
  output logic [1:0]       cmd_end,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             rxw_valid,
  output logic [31:0]      rxw_data,
  input  logic             eng_nak,
  input  logic             eng_done,
  output logic             pkt_done,
  output logic             nak_err,
  output logic             bad_hdr
);
  typedef enum logic [2:0] {S_IDLE, S_LEN, S_FLAGS, S_PAY, S_WAIT, S_DONE} st_t;

  st_t            st;
  logic [LEN_W:0] rem;
  logic [31:0]    wbuf;
  logic [2:0]     wcnt;
  logic [31:0]    rbuf;
  logic [1:0]     rcnt;
  logic           ign_nak;

  logic        nak_hit, tx_fire, rx_fire;
  logic [31:0] rx_merge;

  assign nak_hit  = eng_nak && !ign_nak && (st == S_PAY || st == S_WAIT);
  assign tx_valid = (st == S_PAY) && (wcnt != 3'd0);
  assign tx_byte  = wbuf[7:0];
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_fire  = rx_valid && cmd_read && (st == S_WAIT) && !nak_err && (rem != '0);
  assign rx_merge = rbuf | ({24'd0, rx_byte} << {rcnt, 3'b000});
  assign pkt_done = (st == S_DONE);
  assign fifo_pop = !fifo_empty &&
                    ((st == S_IDLE) || (st == S_LEN) || (st == S_FLAGS) ||
                     ((st == S_PAY) && (wcnt == 3'd0) && !eng_nak));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rem         <= '0;
      wbuf        <= '0;
      wcnt        <= '0;
      rbuf        <= '0;
      rcnt        <= '0;
      ign_nak     <= 1'b0;
      cmd_valid   <= 1'b0;
      cmd_addr    <= '0;
      cmd_ten_bit <= 1'b0;
      cmd_read    <= 1'b0;
      cmd_len     <= '0;
      cmd_end     <= '0;
      rxw_valid   <= 1'b0;
      rxw_data    <= '0;
      nak_err     <= 1'b0;
      bad_hdr     <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      rxw_valid <= 1'b0;
      case (st)
        S_IDLE: if (fifo_pop) begin
          if (fifo_data[4]) st <= S_LEN;
          else              bad_hdr <= 1'b1;
        end
        S_LEN: if (fifo_pop) begin
          rem     <= {1'b0, fifo_data[LEN_W-1:0]} + 1'b1;
          cmd_len <= {1'b0, fifo_data[LEN_W-1:0]} + 1'b1;
          st      <= S_FLAGS;
        end
        S_FLAGS: if (fifo_pop) begin
          cmd_read    <= fifo_data[19];
          cmd_ten_bit <= fifo_data[18];
          cmd_addr    <= fifo_data[18] ? fifo_data[9:0] : {3'b000, fifo_data[7:1]};
          cmd_end     <= fifo_data[16] ? 2'd1 : (fifo_data[15] ? 2'd2 : 2'd0);
          ign_nak     <= fifo_data[21];
          nak_err     <= 1'b0;
          cmd_valid   <= 1'b1;
          wcnt        <= '0;
          rcnt        <= '0;
          rbuf        <= '0;
          st          <= fifo_data[19] ? S_WAIT : S_PAY;
        end
        S_PAY: begin
          if (nak_hit) begin
            nak_err <= 1'b1;
            cmd_end <= 2'd0;
            wcnt    <= '0;
            st      <= S_WAIT;
          end else if (fifo_pop) begin
            wbuf <= fifo_data;
            wcnt <= 3'd4;
          end else if (tx_fire) begin
            wbuf <= wbuf >> 8;
            wcnt <= wcnt - 3'd1;
            rem  <= rem - 1'b1;
            if (rem == 1) begin
              wcnt <= '0;
              st   <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (nak_hit) begin
            nak_err <= 1'b1;
            cmd_end <= 2'd0;
          end
          if (rx_fire) begin
            rem <= rem - 1'b1;
            if (rcnt == 2'd3 || rem == 1) begin
              rxw_valid <= 1'b1;
              rxw_data  <= rx_merge;
              rbuf      <= '0;
              rcnt      <= '0;
            end else begin
              rbuf <= rx_merge;
              rcnt <= rcnt + 2'd1;
            end
          end
          if (eng_done) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pkt_hdr_dec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_pop,
  input logic       fifo_empty,
  input logic       pkt_done,
  input logic       eng_done,
  input logic       bad_hdr,
  input logic       nak_err,
  input logic [1:0] cmd_end,
  input logic       tx_valid,
  input logic       cmd_read
);
  a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);
  a_r9_done_after_eng: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> $past(eng_done));
  a_r2_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bad_hdr |=> bad_hdr);
  a_r10_nak_forces_stop: assert property (@(posedge clk) disable iff (!rst_n)
    nak_err |-> cmd_end == 2'd0);
  a_r5_read_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !cmd_read);
endmodule

bind pkt_hdr_dec pkt_hdr_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_pop(fifo_pop), .fifo_empty(fifo_empty),
  .pkt_done(pkt_done), .eng_done(eng_done), .bad_hdr(bad_hdr),
  .nak_err(nak_err), .cmd_end(cmd_end), .tx_valid(tx_valid), .cmd_read(cmd_read)
);

// File: tb/pkt_hdr_dec_bench.sv
`timescale 1ns/1ps
module pkt_hdr_dec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_empty = 1'b1;
  logic [31:0] fifo_data = '0;
  logic        fifo_pop;
  logic        cmd_valid;
  logic [9:0]  cmd_addr;
  logic        cmd_ten_bit, cmd_read;
  logic [12:0] cmd_len;
  logic [1:0]  cmd_end;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        tx_ready = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rxw_valid;
  logic [31:0] rxw_data;
  logic        eng_nak = 1'b0, eng_done = 1'b0;
  logic        pkt_done, nak_err, bad_hdr;

  int checks = 0, errors = 0;
  logic [31:0] q[$];
  logic [7:0]  cap[$];
  logic [31:0] rxq[$];
  int pops = 0, cmd_n = 0;
  logic [9:0]  c_addr;
  logic        c_ten, c_read;
  logic [12:0] c_len;
  logic [1:0]  c_end;

  always #2 clk = ~clk;

  pkt_hdr_dec u_pkt_hdr_dec (.*);

  task automatic refresh();
    fifo_empty = (q.size() == 0);
    fifo_data  = (q.size() != 0) ? q[0] : 32'd0;
  endtask

  task automatic push(input logic [31:0] w);
    q.push_back(w);
    refresh();
  endtask

  always @(posedge clk) begin
    if (tx_valid && tx_ready) cap.push_back(tx_byte);
    if (rxw_valid) rxq.push_back(rxw_data);
    if (cmd_valid) begin
      c_addr = cmd_addr; c_ten = cmd_ten_bit; c_read = cmd_read;
      c_len = cmd_len; c_end = cmd_end; cmd_n++;
    end
    if (fifo_pop) begin
      #1;
      if (q.size() != 0) void'(q.pop_front());
      pops++;
      refresh();
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cmd(input int n0);
    int g = 0;
    while (cmd_n == n0 && g < 2000) begin @(negedge clk); g++; end
  endtask

  task automatic end_pkt(input string tag);
    @(negedge clk); eng_done = 1'b1;
    @(posedge clk); #1;
    chk(pkt_done == 1'b1, "R9", {tag, " done high"}, pkt_done, 1);
    @(negedge clk); eng_done = 1'b0;
    @(posedge clk); #1;
    chk(pkt_done == 1'b0, "R9", {tag, " done one cycle"}, pkt_done, 0);
  endtask

  task automatic push_hdr(input int len, input logic [31:0] w2);
    push(32'h0001_0010);
    push(32'(len - 1));
    push(w2);
  endtask

  task automatic push_payload(input int len, input logic [7:0] seed);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] word = 32'hEEEE_EEEE;
      for (int k = 0; k < 4; k++)
        if (w * 4 + k < len) word[8*k +: 8] = seed + 8'(w * 4 + k);
      push(word);
    end
  endtask

  task automatic do_write(input string tag, input logic [31:0] w2, input int len,
                          input logic [7:0] seed, input logic [9:0] ea,
                          input logic et, input logic [1:0] ee, input int hold);
    int n0 = cmd_n, g = 0, bad = 0;
    cap.delete();
    tx_ready = (hold == 0);
    push_hdr(len, w2);
    push_payload(len, seed);
    wait_cmd(n0);
    chk(c_len == 13'(len), "R3", {tag, " length"}, c_len, len);
    chk(c_addr == ea && c_ten == et, "R4", {tag, " address"}, {c_ten, c_addr}, {et, ea});
    chk(c_end == ee, "R6", {tag, " end action"}, c_end, ee);
    repeat (hold) @(negedge clk);
    tx_ready = 1'b1;
    while (cap.size() < len && g < 20000) begin @(negedge clk); g++; end
    repeat (3) @(negedge clk);
    chk(cap.size() == len, "R7", {tag, " byte count"}, cap.size(), len);
    for (int i = 0; i < cap.size(); i++) if (cap[i] !== seed + 8'(i)) bad++;
    chk(bad == 0, "R7", {tag, " byte order"}, bad, 0);
    end_pkt(tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!fifo_pop && !cmd_valid && !tx_valid && !rxw_valid, "R1", "idle outputs",
        {fifo_pop, cmd_valid, tx_valid, rxw_valid}, 0);
    chk(!pkt_done && !nak_err && !bad_hdr, "R1", "status outputs",
        {pkt_done, nak_err, bad_hdr}, 0);
  endtask

  task automatic t_read();
    int n0 = cmd_n, p0 = pops;
    rxq.delete();
    push_hdr(6, 32'h0008_0000 | (32'h33 << 1));
    wait_cmd(n0);
    chk(c_read == 1'b1, "R5", "read flag", c_read, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_byte = 8'hA0 + 8'(i);
    end
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(pops - p0 == 3, "R5", "no payload popped", pops - p0, 3);
    chk(rxq.size() == 2, "R5", "rx word count", rxq.size(), 2);
    if (rxq.size() == 2) begin
      chk(rxq[0] == 32'hA3A2_A1A0, "R5", "rx full word", rxq[0], 32'hA3A2_A1A0);
      chk(rxq[1] == 32'h0000_A5A4, "R5", "rx partial word", rxq[1], 32'h0000_A5A4);
    end
    end_pkt("read");
  endtask

  task automatic t_bad_hdr();
    int n0 = cmd_n;
    push(32'h0001_0000);
    repeat (4) @(negedge clk);
    chk(bad_hdr == 1'b1, "R2", "bad header flag", bad_hdr, 1);
    chk(cmd_n == n0 && q.size() == 0, "R2", "word dropped, no command", cmd_n - n0, 0);
    do_write("after bad", 32'h0000_0000 | (32'h11 << 1), 3, 8'h40, 10'h11, 1'b0, 2'd0, 0);
    chk(bad_hdr == 1'b1, "R2", "bad header sticky", bad_hdr, 1);
  endtask

  task automatic t_nak();
    int n0 = cmd_n;
    cap.delete();
    tx_ready = 1'b0;
    push_hdr(8, 32'h0001_0000 | (32'h22 << 1));
    push_payload(8, 8'h60);
    wait_cmd(n0);
    repeat (3) @(negedge clk);
    eng_nak = 1'b1;
    @(negedge clk); eng_nak = 1'b0;
    chk(nak_err == 1'b1, "R10", "nak error flagged", nak_err, 1);
    chk(cmd_end == 2'd0, "R10", "end forced to stop", cmd_end, 0);
    chk(tx_valid == 1'b0, "R10", "byte stream stopped", tx_valid, 0);
    chk(q.size() == 1, "R10", "next payload word kept", q.size(), 1);
    q.delete(); refresh();
    tx_ready = 1'b1;
    end_pkt("nak");
  endtask

  task automatic t_nak_ignored();
    int n0 = cmd_n, g = 0, bad = 0;
    cap.delete();
    tx_ready = 1'b0;
    push_hdr(5, 32'h0020_8000 | (32'h44 << 1));
    push_payload(5, 8'h70);
    wait_cmd(n0);
    repeat (3) @(negedge clk);
    eng_nak = 1'b1;
    @(negedge clk); eng_nak = 1'b0;
    chk(nak_err == 1'b0 && cmd_end == 2'd2, "R10", "ignored nak no effect",
        {nak_err, cmd_end}, 2);
    tx_ready = 1'b1;
    while (cap.size() < 5 && g < 1000) begin @(negedge clk); g++; end
    for (int i = 0; i < cap.size(); i++) if (cap[i] !== 8'h70 + 8'(i)) bad++;
    chk(cap.size() == 5 && bad == 0, "R10", "ignored nak all bytes", cap.size(), 5);
    end_pkt("nak ignored");
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    do_write("w7", 32'h0000_0000 | (32'h5A << 1), 6, 8'h10, 10'h05A, 1'b0, 2'd0, 5);
    do_write("w10", 32'h0005_0000 | 32'h2C5, 1, 8'h20, 10'h2C5, 1'b1, 2'd1, 0);
    do_write("cont", 32'h0000_8000 | (32'h7F << 1), 4, 8'h30, 10'h07F, 1'b0, 2'd2, 2);
    do_write("both", 32'h0001_8000 | (32'h01 << 1), 9, 8'h80, 10'h001, 1'b0, 2'd1, 0);
    t_read();
    t_bad_hdr();
    do_write("max", 32'h0000_0000 | (32'h3C << 1), 4096, 8'h00, 10'h03C, 1'b0, 2'd0, 0);
    t_nak();
    t_nak_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule